// File: doc/BRIEF.md
# Reconfigurable-Feedback LFSR Keystream Generator

This block produces a keystream from several identical linear feedback shift registers. Each register has its own feedback pattern, and that pattern is held in a configuration register that can be changed at run time rather than being fixed. A seed strobe picks a starting point in a small table of primitive polynomials. That table loads the configuration registers, and the rest of the seed fills the shift registers. From the next cycle on, the block advances every register once per clock. It mixes one output tap from each register through a nonlinear function to make one keystream bit, and XORs that bit with the incoming message bit to form the ciphertext bit.

Every shift-register flop and every configuration flop sits on one muxed-D scan chain. When scan enable is high, all of them shift serially from `scan_in` toward `scan_out`, and scan takes priority over both loading and stepping. The keystream, ciphertext and valid outputs are registered.

Top module: `lfsr_keystream`

## Requirements
- R1: After synchronous reset, `ks_valid`, `ks_bit` and `ct_bit` are 0, every shift register holds 0x00, and every configuration register holds 0x01.
- R2: When `load` is high and `scan_en` is low, the seed is captured in one cycle. Bits [SEL_W-1:0] form the table index `sel`. Lane i's shift register takes seed bits [SEL_W+i*SR_W +: SR_W]. Lane i's configuration register takes table entry (sel+i) mod 2^SEL_W, so the index wraps. The default table entries, from 0 to 3, are 0x1D, 0x2B, 0x5F and 0x63.
- R3: On a step cycle, each shift register moves toward stage 1 (bit 0) and its top bit becomes the XOR of the stages whose configuration bit is 1: sr <= {^(sr & cr), sr[SR_W-1:1]}. The configuration register does not change. Every table entry has bit 0 set.
- R4: The keystream bit is the XOR of all pairwise ANDs of the lanes' stage-1 bits, taken before the step. For three lanes this is majority. It is registered on the step edge, and `ks_valid` is high exactly in the cycle after a step.
- R5: `ct_bit` equals `msg_bit` XOR the keystream bit, registered on the same edge as `ks_bit`.
- R6: Between reset and the first load, no stepping occurs. `ks_valid` stays 0 and the state keeps its reset value.
- R7: While `scan_en` is high, the chain shifts by one position per clock, overriding both load and step, and `ks_valid` is 0. Chain position p (the p-th bit out at `scan_out`) is laid out per lane l: lane l's sr[b] sits at p = 16l+b, and lane l's cr[b] sits at p = 16l+8+b. A bit entered at `scan_in` arrives at position 47 and leaves from position 0.
- R8: With all shift-register bits set to 1 and one step applied, the top stage takes the parity of the configuration register and the other stages stay 1. For every table entry the parity is 0, so the result is 0x7F.
- R9: Once stepping has started, a load takes priority over the step and restarts the lanes from the new seed in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Seed capture strobe |
| seed | input | SEL_W+NUM_LFSR*SR_W | Table index field and shift-register initial values |
| msg_bit | input | 1 | Message bit for this cycle |
| scan_en | input | 1 | Scan shift enable |
| scan_in | input | 1 | Serial scan data in |
| scan_out | output | 1 | Serial scan data out (lane 0 stage 1) |
| ks_bit | output | 1 | Registered keystream bit |
| ct_bit | output | 1 | Registered ciphertext bit |
| ks_valid | output | 1 | High in the cycle after a step |

## Verification
The in-line properties check the following on every clock:
- a load places the seed bits in the shift registers;
- a step shifts each register toward stage 1 and leaves its configuration unchanged;
- a scan cycle moves each bit one position along the chain;
- the ciphertext always equals the keystream XOR the previous message bit;
- scan cycles never raise `ks_valid`.

Only the directed scenarios can show the following:
- that the table index wraps across lanes;
- that the feedback and combining function match an independent model over long runs;
- that the all-ones step produces zeros only in the top stage;
- that a scan with load held high leaves the scanned-in data intact;
- that a reload during running restarts the sequence.

// File: rtl/lfsr_ks_pkg.sv
package lfsr_ks_pkg;
  localparam int DEF_NUM_LFSR = 3;
  localparam int DEF_SR_W     = 8;
  localparam int DEF_SEL_W    = 2;
  // Low coefficients of degree-8 primitive polynomials; entry 0 in the low byte.
  localparam logic [(2**DEF_SEL_W)*DEF_SR_W-1:0] DEF_POLY_TABLE = {8'h63, 8'h5F, 8'h2B, 8'h1D};
endpackage

// File: rtl/lfsr_poly_rom.sv
module lfsr_poly_rom #(
  parameter int NUM_LFSR = 3,
  parameter int SR_W     = 8,
  parameter int SEL_W    = 2,
  parameter logic [(2**SEL_W)*SR_W-1:0] POLY_TABLE = lfsr_ks_pkg::DEF_POLY_TABLE
) (
  input  logic [SEL_W-1:0]         sel,
  output logic [NUM_LFSR*SR_W-1:0] cr_init
);
  localparam int DEPTH = 2**SEL_W;

  logic [SR_W-1:0] rom [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_rom
    assign rom[e] = POLY_TABLE[e*SR_W +: SR_W];
  end

  for (genvar i = 0; i < NUM_LFSR; i++) begin : g_lane
    logic [SEL_W-1:0] idx;
    assign idx = sel + SEL_W'(i);
    assign cr_init[i*SR_W +: SR_W] = rom[idx];
  end
endmodule

// File: rtl/lfsr_lane.sv
module lfsr_lane #(
  parameter int SR_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            scan_en,
  input  logic            scan_in,
  input  logic            load,
  input  logic            step,
  input  logic [SR_W-1:0] sr_init,
  input  logic [SR_W-1:0] cr_init,
  output logic            scan_out
);
  localparam logic [SR_W-1:0] CR_RST = {{(SR_W-1){1'b0}}, 1'b1};

  logic [SR_W-1:0] sr;
  logic [SR_W-1:0] cr;
  logic            fb;

  assign fb       = ^(sr & cr);
  assign scan_out = sr[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sr <= '0;
      cr <= CR_RST;
    end else if (scan_en) begin
      {cr, sr} <= {scan_in, cr, sr[SR_W-1:1]};
    end else if (load) begin
      sr <= sr_init;
      cr <= cr_init;
    end else if (step) begin
      sr <= {fb, sr[SR_W-1:1]};
    end
  end

  AST_LOAD_SR: assert property (@(posedge clk) disable iff (rst)
    $past(load && !scan_en && !rst) |-> sr == $past(sr_init)); // R2
  AST_STEP_SHIFT: assert property (@(posedge clk) disable iff (rst)
    $past(step && !scan_en && !load && !rst) |-> sr[SR_W-2:0] == $past(sr[SR_W-1:1])); // R3
  AST_STEP_CR_HOLD: assert property (@(posedge clk) disable iff (rst)
    $past(step && !scan_en && !load && !rst) |-> $stable(cr)); // R3
  AST_SCAN_MOVE: assert property (@(posedge clk) disable iff (rst)
    $past(scan_en && !rst) |-> (cr[SR_W-1] == $past(scan_in)) && (sr[SR_W-1] == $past(cr[0]))); // R7
endmodule

// File: rtl/lfsr_combiner.sv
module lfsr_combiner #(
  parameter int NUM_LFSR = 3
) (
  input  logic [NUM_LFSR-1:0] taps,
  output logic                ks
);
  always_comb begin
    ks = 1'b0;
    for (int i = 0; i < NUM_LFSR; i++) begin
      for (int j = i + 1; j < NUM_LFSR; j++) begin
        ks = ks ^ (taps[i] & taps[j]);
      end
    end
  end
endmodule

// File: rtl/lfsr_keystream.sv
module lfsr_keystream #(
  parameter int NUM_LFSR = lfsr_ks_pkg::DEF_NUM_LFSR,
  parameter int SR_W     = lfsr_ks_pkg::DEF_SR_W,
  parameter int SEL_W    = lfsr_ks_pkg::DEF_SEL_W,
  parameter logic [(2**SEL_W)*SR_W-1:0] POLY_TABLE = lfsr_ks_pkg::DEF_POLY_TABLE
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           load,
  input  logic [SEL_W+NUM_LFSR*SR_W-1:0] seed,
  input  logic                           msg_bit,
  input  logic                           scan_en,
  input  logic                           scan_in,
  output logic                           scan_out,
  output logic                           ks_bit,
  output logic                           ct_bit,
  output logic                           ks_valid
);
  localparam int FILL_W = NUM_LFSR * SR_W;

  logic [NUM_LFSR*SR_W-1:0] cr_init;
  logic [FILL_W-1:0]        sr_fill;
  logic [NUM_LFSR:0]        chain;
  logic [NUM_LFSR-1:0]      taps;
  logic                     run;
  logic                     step;
  logic                     ks_next;

  assign sr_fill         = seed[SEL_W +: FILL_W];
  assign chain[NUM_LFSR] = scan_in;
  assign scan_out        = chain[0];
  assign taps            = chain[NUM_LFSR-1:0];
  assign step            = run && !scan_en && !load;

  lfsr_poly_rom #(
    .NUM_LFSR(NUM_LFSR), .SR_W(SR_W), .SEL_W(SEL_W), .POLY_TABLE(POLY_TABLE)
  ) u_rom (
    .sel    (seed[SEL_W-1:0]),
    .cr_init(cr_init)
  );

  for (genvar i = 0; i < NUM_LFSR; i++) begin : g_lane
    lfsr_lane #(.SR_W(SR_W)) u_lane (
      .clk     (clk),
      .rst     (rst),
      .scan_en (scan_en),
      .scan_in (chain[i+1]),
      .load    (load),
      .step    (step),
      .sr_init (sr_fill[i*SR_W +: SR_W]),
      .cr_init (cr_init[i*SR_W +: SR_W]),
      .scan_out(chain[i])
    );
  end

  lfsr_combiner #(.NUM_LFSR(NUM_LFSR)) u_mix (
    .taps(taps),
    .ks  (ks_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= 1'b0;
      ks_bit   <= 1'b0;
      ct_bit   <= 1'b0;
      ks_valid <= 1'b0;
    end else begin
      if (load && !scan_en) run <= 1'b1;
      ks_valid <= step;
      if (step) begin
        ks_bit <= ks_next;
        ct_bit <= msg_bit ^ ks_next;
      end
    end
  end

  AST_CT_MATCH: assert property (@(posedge clk) disable iff (rst)
    ks_valid |-> ct_bit == (ks_bit ^ $past(msg_bit))); // R5
  AST_SCAN_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(scan_en && !rst) |-> !ks_valid); // R7
  AST_NO_EARLY_RUN: assert property (@(posedge clk) disable iff (rst)
    !run |-> !ks_valid); // R6
endmodule

// File: tb/lfsr_keystream_bench.sv
module lfsr_keystream_bench;
  localparam int N = 3;
  localparam int W = 8;
  localparam int S = 2;
  localparam int CH = N * 2 * W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load = 1'b0;
  logic [S+N*W-1:0] seed = '0;
  logic msg_bit = 1'b0;
  logic scan_en = 1'b0;
  logic scan_in = 1'b0;
  logic scan_out, ks_bit, ct_bit, ks_valid;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [W-1:0] m_sr [N];
  logic [W-1:0] m_cr [N];
  logic [W-1:0] tbl [4] = '{8'h1D, 8'h2B, 8'h5F, 8'h63};

  always #2 clk = ~clk;

  lfsr_keystream u_lfsr_keystream (
    .clk(clk), .rst(rst), .load(load), .seed(seed), .msg_bit(msg_bit),
    .scan_en(scan_en), .scan_in(scan_in), .scan_out(scan_out),
    .ks_bit(ks_bit), .ct_bit(ct_bit), .ks_valid(ks_valid)
  );

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [CH-1:0] model_vec();
    logic [CH-1:0] v;
    for (int l = 0; l < N; l++) begin
      v[l*16 +: 8]     = m_sr[l];
      v[l*16 + 8 +: 8] = m_cr[l];
    end
    return v;
  endfunction

  // Shift a vector in while collecting the old contents (R7 layout).
  task automatic scan_rw(input logic [CH-1:0] vin, output logic [CH-1:0] vout);
    for (int k = 0; k < CH; k++) begin
      scan_en = 1'b1;
      scan_in = vin[k];
      vout[k] = scan_out;
      checks++;
      if (ks_valid !== 1'b0 && k > 0) begin
        errors++;
        $display("FAIL R7 ks_valid during scan: actual %b expected 0", ks_valid);
      end
      cyc();
    end
    scan_en = 1'b0;
    for (int l = 0; l < N; l++) begin
      m_sr[l] = vin[l*16 +: 8];
      m_cr[l] = vin[l*16 + 8 +: 8];
    end
  endtask

  task automatic do_load(input logic [1:0] sel, input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c);
    seed = {c, b, a, sel};
    load = 1'b1;
    cyc();
    load = 1'b0;
    m_sr[0] = a; m_sr[1] = b; m_sr[2] = c;
    for (int l = 0; l < N; l++) m_cr[l] = tbl[(sel + l) % 4];
  endtask

  function automatic logic model_ks();
    int cnt = 0;
    for (int l = 0; l < N; l++) cnt += m_sr[l][0];
    return cnt >= 2;
  endfunction

  task automatic model_step();
    for (int l = 0; l < N; l++) m_sr[l] = {^(m_sr[l] & m_cr[l]), m_sr[l][W-1:1]};
  endtask

  task automatic run_steps(input int n, input int pat);
    for (int t = 0; t < n; t++) begin
      logic ek;
      msg_bit = ((t * pat) >> 1) & 1;
      ek = model_ks();
      model_step();
      cyc();
      check("R4", "ks_valid", 64'(ks_valid), 64'd1);
      check("R4", "ks_bit", 64'(ks_bit), 64'(ek));
      check("R5", "ct_bit", 64'(ct_bit), 64'(ek ^ msg_bit));
    end
  endtask

  task automatic verify_state(input string req);
    logic [CH-1:0] got;
    logic [CH-1:0] exp;
    exp = model_vec();
    scan_rw(exp, got);
    check(req, "scan state", 64'(got), 64'(exp));
  endtask

  task automatic t_reset();
    check("R1", "ks_valid", 64'(ks_valid), 64'd0);
    check("R1", "ks_bit", 64'(ks_bit), 64'd0);
    check("R1", "ct_bit", 64'(ct_bit), 64'd0);
    for (int l = 0; l < N; l++) begin m_sr[l] = '0; m_cr[l] = 8'h01; end
    for (int t = 0; t < 5; t++) begin
      msg_bit = t[0];
      cyc();
      check("R6", "ks_valid before load", 64'(ks_valid), 64'd0);
    end
    verify_state("R1");
  endtask

  task automatic t_load();
    do_load(2'd1, 8'hA5, 8'h3C, 8'hF0);
    check("R2", "ks_valid on load", 64'(ks_valid), 64'd0);
    verify_state("R2");
  endtask

  task automatic t_run();
    run_steps(40, 7);
    verify_state("R3");
  endtask

  task automatic t_wrap();
    do_load(2'd3, 8'h81, 8'h5A, 8'h0F);
    verify_state("R2");
    run_steps(25, 3);
    verify_state("R3");
  endtask

  task automatic t_all_ones();
    logic [CH-1:0] got;
    logic [CH-1:0] v;
    do_load(2'd0, 8'h11, 8'h22, 8'h33);
    for (int l = 0; l < N; l++) m_sr[l] = 8'hFF;
    v = model_vec();
    scan_rw(v, got);
    msg_bit = 1'b0;
    cyc();
    check("R8", "ks after all-ones step", 64'(ks_bit), 64'd1);
    v = model_vec();
    scan_rw(v, got);
    for (int l = 0; l < N; l++) check("R8", "sr after all-ones step", 64'(got[l*16 +: 8]), 64'h7F);
  endtask

  task automatic t_scan_over_load();
    logic [CH-1:0] got;
    logic [CH-1:0] v = 48'h9C3E_71A5_D24B;
    seed = {8'hFF, 8'hFF, 8'hFF, 2'd2};
    load = 1'b1;
    scan_rw(v, got);
    load = 1'b0;
    scan_rw(v, got);
    check("R7", "scan wins over load", 64'(got), 64'(v));
  endtask

  task automatic t_reload();
    logic [CH-1:0] got;
    logic [CH-1:0] v;
    for (int l = 0; l < N; l++) m_cr[l] = tbl[l];
    m_sr[0] = 8'h12; m_sr[1] = 8'h34; m_sr[2] = 8'h56;
    v = model_vec();
    scan_rw(v, got);
    run_steps(6, 5);
    do_load(2'd2, 8'hC3, 8'h01, 8'h7E);
    check("R9", "no valid on reload", 64'(ks_valid), 64'd0);
    verify_state("R9");
    run_steps(10, 1);
    verify_state("R9");
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    rst = 1'b1;
    cyc();
    cyc();
    rst = 1'b0;
    t_reset();
    t_load();
    t_run();
    t_wrap();
    t_all_ones();
    t_scan_over_load();
    t_reload();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule